// File: doc/BRIEF.md
# Multi-Function Timer with Watchdog

This peripheral serves a small 8-bit controller and runs on the bus clock E. A single free-running prescaler chain drives three functions. The first is an 8-bit counter that raises an overflow flag each time it wraps. The second is a periodic tick whose period is chosen by a two-bit rate field, and which raises a periodic flag. The third is a watchdog that counts those same ticks. If software stops servicing the watchdog, the watchdog pulses an internal reset.

Software uses a small register bus with three addresses: a control/status register, a read-only counter register and a watchdog service address. Both flags are sticky. Software removes a flag only by writing a zero to its bit. The interrupt output is a level. It stays high while either flag is set and its enable bit is on. The watchdog cannot be switched off. The wait-mode input does not stop the watchdog or any other part of the chain.

Top module: `mft_timer`

## Requirements
- R1: The counter register (address CNT_ADDR) advances by one every 2^CNT_DIV_LOG E cycles. When it steps from 0xFF to 0x00, the overflow flag (control/status bit 7) becomes 1.
- R2: The periodic flag (control/status bit 6) is set once every 2^(BASE_LOG+rate) E cycles. Here rate is control/status bits 1:0, and 00 selects the shortest period and 11 the longest. With the default BASE_LOG of 11, the periods are E/2048, E/4096, E/8192 and E/16384.
- R3: A flag clears only when software writes 0 to that bit of the control/status register. Writing 1 to a flag bit has no effect. If a set event and a clearing write fall in the same cycle, the flag ends up set.
- R4: irq_o is high exactly when (bit 7 and bit 5) or (bit 6 and bit 4) of the control/status register are both 1. Bit 5 enables the overflow interrupt and bit 4 enables the periodic interrupt.
- R5: The watchdog counts periodic ticks. It times out on the eighth tick after the last service. A service is a write to WDOG_ADDR (default 0x3FF0) with data bit 0 equal to 0. A write there with bit 0 equal to 1 does nothing. A service in the same cycle as the eighth tick prevents the timeout.
- R6: On a timeout, cop_rst_o is high for exactly one cycle. In that same cycle the control/status register, the counter, the prescaler and the watchdog all read as zero.
- R7: wait_i has no effect: the counter, the periodic tick and the watchdog keep running while it is high.
- R8: After reset the control/status and counter registers read 0x00, and irq_o and cop_rst_o are low. Control/status bits 3:2 and any unmapped address read as 0.
- R9: A write to the control/status register loads the two enable bits (5, 4) and the rate field (1:0) directly from the write data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock E |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| wait_i | input | 1 | CPU wait-mode indication |
| irq_o | output | 1 | Level interrupt request |
| cop_rst_o | output | 1 | One-cycle internal reset pulse on watchdog timeout |

## Verification
The bench targets these corner cases and the failure each one catches:
- A clearing write that lands on the very edge where the counter wraps. A design that lets the clear win would lose that overflow.
- Writes of ones to the flag bits. A design that treated them as plain register bits would let software set or toggle the flags.
- Exact tick spacing at all four rates. A wrong tap choice, or an off-by-one in the prescaler mask, shows up as a wrong period.
- Watchdog writes with bit 0 set, which must not count as service. It also measures the timeout window, which should be between seven and eight tick periods after the last real service. A watchdog that miscounts, or that treats any write as service, fires early or never.

// File: rtl/mft_pkg.sv
package mft_pkg;

  localparam int unsigned DATA_W = 8;

  // Control/status bit positions
  localparam int unsigned OVF_FLAG_BIT  = 7;
  localparam int unsigned TICK_FLAG_BIT = 6;
  localparam int unsigned OVF_EN_BIT    = 5;
  localparam int unsigned TICK_EN_BIT   = 4;

  typedef struct packed {
    logic       ovf_flag;
    logic       tick_flag;
    logic       ovf_en;
    logic       tick_en;
    logic [1:0] rate;
  } mft_csr_t;

  // Low-bit mask whose all-ones state marks the end of one periodic interval
  function automatic logic [31:0] tap_mask(input int unsigned base_log,
                                           input logic [1:0]  rate);
    return (32'd1 << (base_log + 32'(rate))) - 32'd1;
  endfunction

  function automatic logic [DATA_W-1:0] pack_csr(input mft_csr_t c);
    return {c.ovf_flag, c.tick_flag, c.ovf_en, c.tick_en, 2'b00, c.rate};
  endfunction

endpackage

// File: rtl/mft_prescaler.sv
module mft_prescaler
  import mft_pkg::*;
#(
  parameter int unsigned BASE_LOG    = 11,
  parameter int unsigned CNT_DIV_LOG = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_clr,
  input  logic [1:0] rate,
  output logic       cnt_tick,
  output logic       rti_tick
);
  localparam int unsigned PRE_W = BASE_LOG + 3;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pre_q <= '0;
    else if (sync_clr) pre_q <= '0;
    else               pre_q <= pre_q + 1'b1;
  end

  assign mask     = PRE_W'(tap_mask(BASE_LOG, rate));
  assign cnt_tick = &pre_q[CNT_DIV_LOG-1:0];
  assign rti_tick = ((pre_q & mask) == mask);

  // R2
  tap_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rti_tick |=> ((pre_q & $past(mask)) == '0));

endmodule

// File: rtl/mft_watchdog.sv
module mft_watchdog #(
  parameter int unsigned TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  input  logic tick,
  output logic expire
);
  localparam int unsigned WD_W = $clog2(TICKS);
  localparam logic [WD_W-1:0] LAST = WD_W'(TICKS - 1);

  logic [WD_W-1:0] wd_q;

  assign expire = tick && (wd_q == LAST) && !kick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wd_q <= '0;
    else if (expire) wd_q <= '0;
    else if (kick)   wd_q <= '0;
    else if (tick)   wd_q <= wd_q + 1'b1;
  end

  // R5
  kick_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (wd_q == '0));

  // R5
  tick_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !kick && (wd_q != LAST)) |=> (wd_q == $past(wd_q) + 1'b1));

endmodule

// File: rtl/mft_flags.sv
module mft_flags
  import mft_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_clr,
  input  logic              cnt_tick,
  input  logic              rti_tick,
  input  logic              csr_we,
  input  mft_csr_t          wr_csr,
  output mft_csr_t          csr_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic wrap;
  logic clr_ovf, clr_tick;

  assign wrap     = cnt_tick && (&cnt_o);
  assign clr_ovf  = csr_we && !wr_csr.ovf_flag;
  assign clr_tick = csr_we && !wr_csr.tick_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o <= '0;
      csr_o <= '0;
    end else if (sync_clr) begin
      cnt_o <= '0;
      csr_o <= '0;
    end else begin
      if (cnt_tick) cnt_o <= cnt_o + 1'b1;
      csr_o.ovf_flag  <= wrap     | (csr_o.ovf_flag  & !clr_ovf);
      csr_o.tick_flag <= rti_tick | (csr_o.tick_flag & !clr_tick);
      if (csr_we) begin
        csr_o.ovf_en  <= wr_csr.ovf_en;
        csr_o.tick_en <= wr_csr.tick_en;
        csr_o.rate    <= wr_csr.rate;
      end
    end
  end

  // R1
  wrap_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !sync_clr) |=> csr_o.ovf_flag);

  // R3
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_o.ovf_flag && !sync_clr && !csr_we) |=> csr_o.ovf_flag);

  // R3
  tick_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_o.tick_flag && !sync_clr && !csr_we) |=> csr_o.tick_flag);

  // R6
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_clr |=> ((csr_o == '0) && (cnt_o == '0)));

endmodule

// File: rtl/mft_timer.sv
module mft_timer
  import mft_pkg::*;
#(
  parameter int unsigned     ADDR_W      = 14,
  parameter logic [ADDR_W-1:0] CSR_ADDR  = 'h0008,
  parameter logic [ADDR_W-1:0] CNT_ADDR  = 'h0009,
  parameter logic [ADDR_W-1:0] WDOG_ADDR = 'h3FF0,
  parameter int unsigned     BASE_LOG    = 11,
  parameter int unsigned     CNT_DIV_LOG = 2,
  parameter int unsigned     WD_TICKS    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              wait_i,
  output logic              irq_o,
  output logic              cop_rst_o
);
  localparam int unsigned CNT_W = DATA_W;

  mft_csr_t         csr;
  mft_csr_t         wr_csr;
  logic [CNT_W-1:0] cnt;
  logic             csr_we, kick;
  logic             cnt_tick, rti_tick, expire;
  logic             cop_q;
  logic             unused_inputs;

  assign csr_we = bus_wr && (bus_addr == CSR_ADDR);
  assign kick   = bus_wr && (bus_addr == WDOG_ADDR) && !bus_wdata[0];
  assign wr_csr = '{ovf_flag:  bus_wdata[OVF_FLAG_BIT],
                    tick_flag: bus_wdata[TICK_FLAG_BIT],
                    ovf_en:    bus_wdata[OVF_EN_BIT],
                    tick_en:   bus_wdata[TICK_EN_BIT],
                    rate:      bus_wdata[1:0]};
  assign unused_inputs = ^{bus_wdata[3:2], wait_i};

  mft_prescaler #(.BASE_LOG(BASE_LOG), .CNT_DIV_LOG(CNT_DIV_LOG)) u_pre (
    .clk(clk), .rst_n(rst_n), .sync_clr(expire), .rate(csr.rate),
    .cnt_tick(cnt_tick), .rti_tick(rti_tick));

  mft_flags #(.CNT_W(CNT_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .sync_clr(expire), .cnt_tick(cnt_tick),
    .rti_tick(rti_tick), .csr_we(csr_we), .wr_csr(wr_csr),
    .csr_o(csr), .cnt_o(cnt));

  mft_watchdog #(.TICKS(WD_TICKS)) u_wd (
    .clk(clk), .rst_n(rst_n), .kick(kick), .tick(rti_tick), .expire(expire));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cop_q <= 1'b0;
    else        cop_q <= expire;
  end

  assign cop_rst_o = cop_q;
  assign irq_o     = (csr.ovf_flag & csr.ovf_en) | (csr.tick_flag & csr.tick_en);

  always_comb begin
    if (bus_addr == CSR_ADDR)      bus_rdata = pack_csr(csr);
    else if (bus_addr == CNT_ADDR) bus_rdata = cnt;
    else                           bus_rdata = '0;
  end

  // R6
  cop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cop_rst_o |=> !cop_rst_o);

  // R7
  wait_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_i && cnt_tick && !expire) |=> (cnt == $past(cnt) + 1'b1));

  // R4
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !bus_wr && !expire) |=> irq_o);

endmodule

// File: tb/mft_timer_tb.sv
module mft_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 14;
  localparam int BASE = 4;
  localparam int CDL = 1;
  localparam logic [ADDR_W-1:0] A_CSR = 14'h0008;
  localparam logic [ADDR_W-1:0] A_CNT = 14'h0009;
  localparam logic [ADDR_W-1:0] A_WD  = 14'h3FF0;

  logic clk = 0, rst_n = 0, bus_wr = 0, wait_i = 0;
  logic [ADDR_W-1:0] bus_addr = A_CNT;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic irq_o, cop_rst_o;

  int tests = 0, fails = 0, cyc = 0;

  // behavioural reference state
  int m_pre = 0, m_cnt = 0, m_wd = 0, m_rate = 0;
  bit m_ovf = 0, m_tick = 0, m_oen = 0, m_ten = 0, m_cop = 0;

  mft_timer #(.ADDR_W(ADDR_W), .CSR_ADDR(A_CSR), .CNT_ADDR(A_CNT),
              .WDOG_ADDR(A_WD), .BASE_LOG(BASE), .CNT_DIV_LOG(CDL),
              .WD_TICKS(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wait_i(wait_i),
    .irq_o(irq_o), .cop_rst_o(cop_rst_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int m_read(logic [ADDR_W-1:0] a);
    if (a == A_CSR) return (int'(m_ovf) << 7) | (int'(m_tick) << 6) |
                           (int'(m_oen) << 5) | (int'(m_ten) << 4) | m_rate;
    if (a == A_CNT) return m_cnt;
    return 0;
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // reference model, one step per rising edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_wd = 0; m_rate = 0;
      m_ovf = 0; m_tick = 0; m_oen = 0; m_ten = 0; m_cop = 0;
    end else begin
      int per;
      bit ct, rt, kick, wcsr, expire;
      per    = 1 << (BASE + m_rate);
      ct     = (m_pre % (1 << CDL)) == (1 << CDL) - 1;
      rt     = (m_pre % per) == per - 1;
      kick   = bus_wr && bus_addr == A_WD && !bus_wdata[0];
      wcsr   = bus_wr && bus_addr == A_CSR;
      expire = rt && m_wd == 7 && !kick;
      m_cop  = expire;
      if (expire) begin
        m_pre = 0; m_cnt = 0; m_wd = 0; m_rate = 0;
        m_ovf = 0; m_tick = 0; m_oen = 0; m_ten = 0;
      end else begin
        if (wcsr && !bus_wdata[7]) m_ovf = 0;
        if (wcsr && !bus_wdata[6]) m_tick = 0;
        if (ct && m_cnt == 255) m_ovf = 1;
        if (rt) m_tick = 1;
        if (ct) m_cnt = (m_cnt + 1) % 256;
        if (wcsr) begin
          m_oen = bus_wdata[5]; m_ten = bus_wdata[4]; m_rate = int'(bus_wdata[1:0]);
        end
        if (kick) m_wd = 0;
        else if (rt) m_wd = m_wd + 1;
        m_pre = (m_pre + 1) % (1 << (BASE + 3));
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(int'(irq_o), int'((m_ovf && m_oen) || (m_tick && m_ten)), "R4 irq_o");
      chk(int'(cop_rst_o), int'(m_cop), "R6 cop_rst_o");
      chk(int'(bus_rdata), m_read(bus_addr),
          bus_addr == A_CSR ? "R3 csr read" : (bus_addr == A_CNT ? "R1 cnt read" : "R8 other read"));
    end
  end

  task automatic drive(input logic [ADDR_W-1:0] a, input logic w, input logic [7:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wr = w; bus_wdata = d;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    drive(a, 1, d);
    drive(A_CSR, 0, 0);
  endtask

  task automatic read_chk(input logic [ADDR_W-1:0] a, input int mask, input int exp, input string tag);
    drive(a, 0, 0);
    @(negedge clk);
    chk(int'(bus_rdata) & mask, exp, tag);
  endtask

  // poll a CSR bit, return the cycle at which it was seen
  task automatic wait_bit(input int b, input int lim, output int t, output bit seen);
    seen = 0; t = 0;
    drive(A_CSR, 0, 0);
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (bus_rdata[b]) begin seen = 1; t = cyc; break; end
    end
  endtask

  initial begin
    int t1, t2, t0, n;
    bit seen;
    // R8 reset state
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(int'(bus_rdata), 0, "R8 counter after reset");
    chk(int'(irq_o), 0, "R8 irq after reset");
    chk(int'(cop_rst_o), 0, "R8 cop after reset");
    read_chk(A_CSR, 8'hFF, 0, "R8 csr after reset");
    read_chk(14'h0100, 8'hFF, 0, "R8 unmapped address");

    // R9 enables and rate load; R3 ones to flags do nothing
    wr(A_CSR, 8'hFF);
    read_chk(A_CSR, 8'hFF, 8'h33, "R9 csr load");

    // R1 overflow while in wait mode (R7)
    wait_i = 1;
    wr(A_WD, 8'h00);
    wait_bit(7, 700, t1, seen);
    chk(int'(seen), 1, "R1 overflow flag set");
    chk(int'(irq_o), 1, "R4 irq with overflow enabled");
    wr(A_WD, 8'h00);
    wr(A_CSR, 8'hF3);
    read_chk(A_CSR, 8'h80, 8'h80, "R3 write 1 keeps overflow flag");
    wr(A_CSR, 8'h43);
    read_chk(A_CSR, 8'h80, 8'h00, "R3 write 0 clears overflow flag");
    wait_i = 0;

    // R4 flag without enable gives no interrupt
    wr(A_CSR, 8'h00);
    wr(A_WD, 8'h00);
    wait_bit(6, 300, t1, seen);
    chk(int'(seen), 1, "R2 periodic flag set");
    chk(int'(irq_o), 0, "R4 no irq when disabled");

    // R2 tick spacing at each rate
    for (int r = 0; r < 4; r++) begin
      wr(A_WD, 8'h00);
      wr(A_CSR, 8'(r));
      wait_bit(6, 300, t1, seen);
      wr(A_CSR, 8'(r));
      wait_bit(6, 300, t2, seen);
      chk(t2 - t1, 1 << (BASE + r), $sformatf("R2 period at rate %0d", r));
    end

    // R3 set wins against clear on the wrap edge
    wr(A_CSR, 8'h03);
    wr(A_WD, 8'h00);
    for (int k = 0; k < 1000; k++) begin
      @(posedge clk); #1;
      if (m_cnt == 255 && (m_pre % 2) == 1) begin
        bus_addr = A_CSR; bus_wr = 1; bus_wdata = 8'h03;
        break;
      end else if (k % 40 == 0) begin
        bus_addr = A_WD; bus_wr = 1; bus_wdata = 8'h00;
      end else begin
        bus_addr = A_CSR; bus_wr = 0;
      end
    end
    read_chk(A_CSR, 8'h80, 8'h80, "R3 set wins over clear");

    // R5/R6 timeout at rate 1
    wr(A_CSR, 8'h01);
    drive(A_WD, 1, 8'h00);
    drive(A_CNT, 0, 0);
    t0 = cyc - 1;
    seen = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (cop_rst_o) begin seen = 1; break; end
    end
    n = cyc - t0;
    chk(int'(seen && n > 224 && n <= 256), 1, $sformatf("R5 timeout window n=%0d", n));
    chk(int'(bus_rdata), 0, "R6 counter zero on timeout");
    @(negedge clk);
    chk(int'(cop_rst_o), 0, "R6 single-cycle pulse");
    read_chk(A_CSR, 8'hFF, 0, "R6 csr zero after timeout");

    // R5 writes with bit 0 set are not a service (rate 0 after timeout)
    drive(A_WD, 1, 8'h00);
    t0 = cyc;
    seen = 0;
    for (int i = 0; i < 300; i++) begin
      if (i % 10 == 5) drive(A_WD, 1, 8'h01);
      else drive(A_CSR, 0, 0);
      @(negedge clk);
      if (cop_rst_o) begin seen = 1; break; end
    end
    n = cyc - t0;
    chk(int'(seen && n > 112 && n <= 128), 1, $sformatf("R5 ignored service n=%0d", n));

    drive(A_CSR, 0, 0);
    repeat (4) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    tests++; fails++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule